// File: doc/BRIEF.md
# Predicated SIMD Lane Execution Unit

This block is the execute stage of a single-issue SIMD group. A row of lanes shares one stream of decoded instructions. Each lane holds a small register file, a two-bit condition code and a private word memory. Branches inside the group are not taken. Instead, each instruction carries a predicate selector. A lane commits the instruction only when its condition code meets that selector and the lane is enabled in the active mask. A lane that fails either test treats the instruction as a no-operation.

An active-mask stack serializes divergent regions. A push narrows the mask to the lanes whose predicate holds. An else switches to the complementary lanes within the enclosing mask. A pop restores the enclosing mask. Nesting depth is a parameter. A vote instruction reduces the predicate over the active lanes into group-wide any and all flags.

Every accepted instruction takes exactly one issue cycle, even when no lane commits it. A load is the one exception: its data returns one cycle later, and the unit reports busy for that cycle and accepts no instruction during it.

Top module: `simt_lane_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the active mask is all ones, and busy, stack_err, vote_any, vote_all and res_commit are all zero. All registers, condition codes and memory words read as zero.
- R2: Instruction effects are registered at the edge on which the instruction is accepted. The write operations are op 1 (rd = imm), op 2 (rd = lane index), op 3 (rd = rs1 + rs2) and op 4 (rd = rs1 + imm), all modulo 2^DW. Each enabled lane writes its result into rd. On the next cycle it shows the result in its slice of res_data (lane l at bits l*DW and up) and sets its res_commit bit. A lane that does not commit keeps its previous res_data slice.
- R3: Op 5 compares rs1 with imm and writes the lane's condition code: equal = (rs1 == imm) and less = (rs1 < imm), both as signed DW-bit values. It writes no register and sets no res_commit bit.
- R4: The predicate selector values are 0 always, 1 equal, 2 not equal, 3 less, 4 greater-or-equal, 5 greater, 6 less-or-equal and 7 never. A lane is enabled when its active-mask bit is 1 and its selected predicate is true. A lane that is not enabled changes no register, no condition code and no memory word, and does not commit.
- R5: Every instruction presented while busy is 0 is accepted and occupies one cycle, even when no lane is enabled. Busy stays 0 after any instruction other than a load.
- R6: Op 7 stores rs2 into the lane's memory word at address rs1 mod MEM_WORDS. Op 6 reads that word into rd. The load result reaches rd, res_data and res_commit one cycle later than a write operation would. Busy is 1 for exactly that one cycle, and an instruction presented while busy is 1 is discarded.
- R7: Op 8 pushes the current mask and sets the mask to mask AND predicate. Op 9 sets the mask to the top saved mask AND NOT the current mask. Op 10 restores the top saved mask and removes it. Up to DEPTH regions may be nested.
- R8: A push when DEPTH masks are already saved, or an else or pop when none are saved, leaves the mask and the stack unchanged. It sets stack_err, which stays 1 until reset.
- R9: Op 11 updates vote_any and vote_all, which hold their values until the next vote. vote_any is 1 when at least one active lane's selected predicate is true. vote_all is 1 when every active lane's selected predicate is true, and is therefore 1 when no lane is active.
- R10: Op 12 shows rs1 on res_data for the enabled lanes and commits them, without writing any register. Op 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | A decoded instruction is presented |
| issue_op | input | 4 | Operation code |
| issue_pred | input | 3 | Predicate selector |
| issue_rd | input | RAW | Destination register |
| issue_rs1 | input | RAW | First source register (also memory address) |
| issue_rs2 | input | RAW | Second source register (also store data) |
| issue_imm | input | DW | Immediate value |
| busy | output | 1 | Load return cycle; input is discarded |
| res_data | output | LANES*DW | Per-lane last committed result |
| res_commit | output | LANES | Lanes that committed in the previous cycle |
| act_mask | output | LANES | Current active-lane mask |
| vote_any | output | 1 | Some active lane satisfied the vote predicate |
| vote_all | output | 1 | Every active lane satisfied the vote predicate |
| stack_err | output | 1 | Sticky mask-stack overflow or underflow |

## Verification
The bench targets the signed compare with a negative operand: a design that compared unsigned would select the wrong lanes under less. It presents an instruction during the load return cycle, which a design without the stall would execute. It issues an else inside a nested region, where a design that inverted the full mask instead of the parent would wake lanes disabled by the outer region. It votes with no active lanes, where a design that counted inactive lanes, or that failed to treat an empty set as vacuously true, would report the wrong any or all value. It also underflows and overflows the stack, which a design without the guard would corrupt instead of flagging.

// File: rtl/simt_pkg.sv
package simt_pkg;
   typedef enum logic [3:0] {
      OP_NOP  = 4'd0,
      OP_MOVI = 4'd1,
      OP_LANE = 4'd2,
      OP_ADD  = 4'd3,
      OP_ADDI = 4'd4,
      OP_CMP  = 4'd5,
      OP_LD   = 4'd6,
      OP_ST   = 4'd7,
      OP_PUSH = 4'd8,
      OP_ELSE = 4'd9,
      OP_POP  = 4'd10,
      OP_VOTE = 4'd11,
      OP_READ = 4'd12
   } op_e;

   // predicate selector on condition code {eq, lt}
   function automatic logic pred_eval(input logic [2:0] sel, input logic eq, input logic lt);
      logic r;
      case (sel)
         3'd0:    r = 1'b1;
         3'd1:    r = eq;
         3'd2:    r = ~eq;
         3'd3:    r = lt;
         3'd4:    r = ~lt;
         3'd5:    r = ~lt & ~eq;
         3'd6:    r = lt | eq;
         default: r = 1'b0;
      endcase
      return r;
   endfunction

   function automatic logic op_writes(input op_e op);
      return (op == OP_MOVI) || (op == OP_LANE) || (op == OP_ADD) || (op == OP_ADDI);
   endfunction
endpackage

// File: rtl/simt_lane.sv
module simt_lane
   import simt_pkg::*;
#(
   parameter int DW        = 16,
   parameter int NREGS     = 4,
   parameter int MEM_WORDS = 8,
   parameter int LANE_ID   = 0,
   localparam int RAW = $clog2(NREGS),
   localparam int MAW = $clog2(MEM_WORDS)
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           issue,
   input  op_e            op,
   input  logic [2:0]     sel,
   input  logic [RAW-1:0] rd,
   input  logic [RAW-1:0] rs1,
   input  logic [RAW-1:0] rs2,
   input  logic [DW-1:0]  imm,
   input  logic           active,
   input  logic           ld_wb,
   output logic           pred,
   output logic [DW-1:0]  res,
   output logic           commit
);
   localparam logic [DW-1:0] ID_VAL = DW'(LANE_ID);

   logic [DW-1:0]  rf  [NREGS];
   logic [DW-1:0]  mem [MEM_WORDS];
   logic           cc_eq, cc_lt;
   logic [DW-1:0]  ld_q;
   logic [RAW-1:0] ld_rd;
   logic           ld_en;
   logic [DW-1:0]  a, b, alu;
   logic           en, shows;

   assign pred  = pred_eval(sel, cc_eq, cc_lt);
   assign en    = issue & active & pred;
   assign a     = rf[rs1];
   assign b     = rf[rs2];
   assign shows = op_writes(op) || (op == OP_READ);

   always_comb begin
      case (op)
         OP_MOVI: alu = imm;
         OP_LANE: alu = ID_VAL;
         OP_ADD:  alu = a + b;
         OP_ADDI: alu = a + imm;
         default: alu = a;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) rf[i] <= '0;
         for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
         cc_eq  <= 1'b0;
         cc_lt  <= 1'b0;
         ld_q   <= '0;
         ld_rd  <= '0;
         ld_en  <= 1'b0;
         res    <= '0;
         commit <= 1'b0;
      end else if (ld_wb) begin
         if (ld_en) begin
            rf[ld_rd] <= ld_q;
            res       <= ld_q;
         end
         commit <= ld_en;
         ld_en  <= 1'b0;
      end else begin
         commit <= en & shows;
         if (en & shows) res <= alu;
         if (en & op_writes(op)) rf[rd] <= alu;
         if (en && op == OP_CMP) begin
            cc_eq <= (a == imm);
            cc_lt <= ($signed(a) < $signed(imm));
         end
         if (en && op == OP_ST) mem[a[MAW-1:0]] <= b;
         if (issue && op == OP_LD) begin
            ld_en <= en;
            ld_q  <= mem[a[MAW-1:0]];
            ld_rd <= rd;
         end
      end
   end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
   parameter int LANES = 8,
   parameter int DEPTH = 4,
   localparam int SPW = $clog2(DEPTH + 1),
   localparam int IW  = $clog2(DEPTH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             flip,
   input  logic             pop,
   input  logic [LANES-1:0] cond,
   output logic [LANES-1:0] mask,
   output logic             err
);
   logic [LANES-1:0] stk [DEPTH];
   logic [SPW-1:0]   sp;
   logic [IW-1:0]    top_idx, put_idx;
   logic             full, empty;

   assign full    = (sp == SPW'(DEPTH));
   assign empty   = (sp == '0);
   assign top_idx = IW'(sp - 1'b1);
   assign put_idx = IW'(sp);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
         sp   <= '0;
         mask <= '1;
         err  <= 1'b0;
      end else if (push) begin
         if (full) err <= 1'b1;
         else begin
            stk[put_idx] <= mask;
            mask         <= mask & cond;
            sp           <= sp + 1'b1;
         end
      end else if (flip) begin
         if (empty) err <= 1'b1;
         else mask <= stk[top_idx] & ~mask;
      end else if (pop) begin
         if (empty) err <= 1'b1;
         else begin
            mask <= stk[top_idx];
            sp   <= sp - 1'b1;
         end
      end
   end

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(err) |-> err);

   // R7
   push_narrows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> ((mask & ~$past(mask)) == '0));
endmodule

// File: rtl/simt_vote.sv
module simt_vote #(
   parameter int LANES = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample,
   input  logic [LANES-1:0] active,
   input  logic [LANES-1:0] pred,
   output logic             any_q,
   output logic             all_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         any_q <= 1'b0;
         all_q <= 1'b0;
      end else if (sample) begin
         any_q <= |(active & pred);
         all_q <= &(~active | pred);
      end
   end

   // R9
   vote_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sample |=> ($stable(any_q) && $stable(all_q)));
endmodule

// File: rtl/simt_lane_unit.sv
module simt_lane_unit
   import simt_pkg::*;
#(
   parameter int LANES     = 8,
   parameter int DW        = 16,
   parameter int NREGS     = 4,
   parameter int MEM_WORDS = 8,
   parameter int DEPTH     = 4,
   localparam int RAW = $clog2(NREGS)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                issue_valid,
   input  logic [3:0]          issue_op,
   input  logic [2:0]          issue_pred,
   input  logic [RAW-1:0]      issue_rd,
   input  logic [RAW-1:0]      issue_rs1,
   input  logic [RAW-1:0]      issue_rs2,
   input  logic [DW-1:0]       issue_imm,
   output logic                busy,
   output logic [LANES*DW-1:0] res_data,
   output logic [LANES-1:0]    res_commit,
   output logic [LANES-1:0]    act_mask,
   output logic                vote_any,
   output logic                vote_all,
   output logic                stack_err
);
   initial begin
      lanes_param_chk: assert (LANES >= 1) else $error("LANES must be at least 1");
      regs_param_chk:  assert (NREGS >= 2 && (NREGS & (NREGS - 1)) == 0)
         else $error("NREGS must be a power of two, at least 2");
      mem_param_chk:   assert (MEM_WORDS >= 2 && (MEM_WORDS & (MEM_WORDS - 1)) == 0)
         else $error("MEM_WORDS must be a power of two, at least 2");
      depth_param_chk: assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      width_param_chk: assert (DW >= $clog2(MEM_WORDS) && DW >= $clog2(LANES))
         else $error("DW too narrow for address or lane index");
   end

   op_e              op;
   logic             accepted;
   logic [LANES-1:0] pred_v;

   assign op       = op_e'(issue_op);
   assign accepted = issue_valid & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) busy <= 1'b0;
      else        busy <= accepted && (op == OP_LD);
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      simt_lane #(
         .DW(DW), .NREGS(NREGS), .MEM_WORDS(MEM_WORDS), .LANE_ID(l)
      ) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .issue  (accepted),
         .op     (op),
         .sel    (issue_pred),
         .rd     (issue_rd),
         .rs1    (issue_rs1),
         .rs2    (issue_rs2),
         .imm    (issue_imm),
         .active (act_mask[l]),
         .ld_wb  (busy),
         .pred   (pred_v[l]),
         .res    (res_data[l*DW +: DW]),
         .commit (res_commit[l])
      );
   end

   simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (accepted && op == OP_PUSH),
      .flip  (accepted && op == OP_ELSE),
      .pop   (accepted && op == OP_POP),
      .cond  (pred_v),
      .mask  (act_mask),
      .err   (stack_err)
   );

   simt_vote #(.LANES(LANES)) u_vote (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (accepted && op == OP_VOTE),
      .active (act_mask),
      .pred   (pred_v),
      .any_q  (vote_any),
      .all_q  (vote_all)
   );

   // R4
   masked_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((res_commit & ~$past(act_mask)) == '0));

   // R6
   busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   // R5
   busy_only_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(accepted && op == OP_LD));
endmodule

// File: tb/simt_lane_unit_tb.sv
module simt_lane_unit_tb;
   localparam int LANES = 8;
   localparam int DW    = 16;
   localparam int NREGS = 4;
   localparam int MW    = 8;
   localparam int DEPTH = 4;
   localparam int RAW   = $clog2(NREGS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic iv = 1'b0;
   logic [3:0] iop = '0;
   logic [2:0] ipr = '0;
   logic [RAW-1:0] ird = '0, irs1 = '0, irs2 = '0;
   logic [DW-1:0] iimm = '0;
   logic busy, vany, vall, serr;
   logic [LANES*DW-1:0] rdata;
   logic [LANES-1:0] rcommit, amask;

   always #5 clk = ~clk;

   simt_lane_unit #(.LANES(LANES), .DW(DW), .NREGS(NREGS), .MEM_WORDS(MW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .issue_valid(iv), .issue_op(iop), .issue_pred(ipr),
      .issue_rd(ird), .issue_rs1(irs1), .issue_rs2(irs2), .issue_imm(iimm),
      .busy(busy), .res_data(rdata), .res_commit(rcommit), .act_mask(amask),
      .vote_any(vany), .vote_all(vall), .stack_err(serr));

   int n_chk = 0, n_fail = 0;
   string phase = "R1";

   // behavioural reference state
   logic [DW-1:0] m_rf [LANES][NREGS];
   logic [DW-1:0] m_mem [LANES][MW];
   bit m_eq [LANES], m_lt [LANES];
   logic [DW-1:0] m_res [LANES], m_ldq [LANES];
   bit m_lden [LANES];
   int m_ldrd;
   logic [LANES-1:0] m_mask, m_commit;
   logic [LANES-1:0] m_stk [$];
   bit m_err, m_any, m_all, m_busy;

   task automatic chk(string tag, string what, logic [LANES*DW-1:0] act, logic [LANES*DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic bit bpred(int s, bit eq, bit lt);
      case (s)
         0: return 1;
         1: return eq;
         2: return !eq;
         3: return lt;
         4: return !lt;
         5: return !(lt || eq);
         6: return lt || eq;
         default: return 0;
      endcase
   endfunction

   task automatic model_reset();
      for (int l = 0; l < LANES; l++) begin
         for (int r = 0; r < NREGS; r++) m_rf[l][r] = '0;
         for (int w = 0; w < MW; w++) m_mem[l][w] = '0;
         m_eq[l] = 0; m_lt[l] = 0; m_res[l] = '0; m_ldq[l] = '0; m_lden[l] = 0;
      end
      m_ldrd = 0; m_mask = '1; m_commit = '0; m_stk.delete();
      m_err = 0; m_any = 0; m_all = 0; m_busy = 0;
   endtask

   task automatic model_cycle(bit v, int o, int s, int d, int r1, int r2, logic [DW-1:0] im);
      logic [LANES-1:0] p, en;
      logic [DW-1:0] a, b, val;
      m_commit = '0;
      if (m_busy) begin
         for (int l = 0; l < LANES; l++)
            if (m_lden[l]) begin
               m_rf[l][m_ldrd] = m_ldq[l]; m_res[l] = m_ldq[l]; m_commit[l] = 1;
               m_lden[l] = 0;
            end
         m_busy = 0;
         return;
      end
      if (!v) return;
      for (int l = 0; l < LANES; l++) begin
         p[l] = bpred(s, m_eq[l], m_lt[l]);
         en[l] = p[l] && m_mask[l];
      end
      for (int l = 0; l < LANES; l++) begin
         a = m_rf[l][r1]; b = m_rf[l][r2];
         case (o)
            1: val = im;
            2: val = DW'(l);
            3: val = a + b;
            4: val = a + im;
            default: val = a;
         endcase
         if (en[l]) begin
            if (o >= 1 && o <= 4) m_rf[l][d] = val;
            if ((o >= 1 && o <= 4) || o == 12) begin m_res[l] = val; m_commit[l] = 1; end
            if (o == 5) begin m_eq[l] = (a == im); m_lt[l] = ($signed(a) < $signed(im)); end
            if (o == 7) m_mem[l][int'(a) % MW] = b;
         end
         if (o == 6) begin m_ldq[l] = m_mem[l][int'(a) % MW]; m_lden[l] = en[l]; end
      end
      case (o)
         6: begin m_busy = 1; m_ldrd = d; end
         8: if (m_stk.size() == DEPTH) m_err = 1;
            else begin m_stk.push_back(m_mask); m_mask = m_mask & p; end
         9: if (m_stk.size() == 0) m_err = 1;
            else m_mask = m_stk[m_stk.size()-1] & ~m_mask;
         10: if (m_stk.size() == 0) m_err = 1;
             else m_mask = m_stk.pop_back();
         11: begin m_any = |(m_mask & p); m_all = &(~m_mask | p); end
         default: ;
      endcase
   endtask

   task automatic compare_all();
      logic [LANES*DW-1:0] exp;
      for (int l = 0; l < LANES; l++) exp[l*DW +: DW] = m_res[l];
      chk(phase, "res_data", rdata, exp);
      chk(phase, "res_commit", LANES*DW'(rcommit), LANES*DW'(m_commit));
      chk(phase, "act_mask", LANES*DW'(amask), LANES*DW'(m_mask));
      chk(phase, "stack_err", LANES*DW'(serr), LANES*DW'(m_err));
      chk(phase, "vote_any", LANES*DW'(vany), LANES*DW'(m_any));
      chk(phase, "vote_all", LANES*DW'(vall), LANES*DW'(m_all));
      chk(phase, "busy", LANES*DW'(busy), LANES*DW'(m_busy));
   endtask

   task automatic step(bit v, int o, int s, int d, int r1, int r2, logic [DW-1:0] im);
      iv = v; iop = 4'(o); ipr = 3'(s); ird = RAW'(d); irs1 = RAW'(r1); irs2 = RAW'(r2); iimm = im;
      model_cycle(v, o, s, d, r1, r2, im);
      @(posedge clk);
      @(negedge clk);
      iv = 0;
      compare_all();
   endtask

   task automatic do_reset();
      rst_n = 0; iv = 0;
      model_reset();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      phase = "R1";
      chk("R1", "mask after reset", LANES*DW'(amask), LANES*DW'({LANES{1'b1}}));
      chk("R1", "busy after reset", LANES*DW'(busy), '0);
      chk("R1", "err after reset", LANES*DW'(serr), '0);
      chk("R1", "commit after reset", LANES*DW'(rcommit), '0);
      compare_all();
   endtask

   bit done = 0;
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      step(1, 12, 0, 0, 1, 0, 0);              // R1 registers read zero
      phase = "R2";
      step(1, 1, 0, 1, 0, 0, 16'd5);
      step(1, 2, 0, 0, 0, 0, 0);
      step(1, 3, 0, 2, 0, 1, 0);
      step(1, 4, 0, 3, 2, 0, 16'd100);
      step(1, 4, 0, 3, 3, 0, 16'hFFFF);        // R2 wraparound
      phase = "R3";
      step(1, 5, 0, 0, 0, 0, 16'd3);
      for (int s = 0; s < 8; s++) step(1, 12, s, 0, 0, 0, 0);
      step(1, 1, 0, 1, 0, 0, 16'hFFFE);
      step(1, 5, 0, 0, 1, 0, 16'd1);           // R3 signed: -2 < 1
      step(1, 12, 3, 0, 1, 0, 0);
      step(1, 5, 0, 0, 0, 0, 16'd3);
      phase = "R4";
      step(1, 4, 2, 1, 1, 0, 16'd1);
      step(1, 12, 0, 0, 1, 0, 0);
      step(1, 5, 3, 0, 0, 0, 16'd1);           // predicated compare
      step(1, 12, 1, 0, 0, 0, 0);
      phase = "R5";
      step(1, 1, 7, 2, 0, 0, 16'hBEEF);
      chk("R5", "never commit", LANES*DW'(rcommit), '0);
      chk("R5", "never busy", LANES*DW'(busy), '0);
      step(1, 12, 0, 0, 2, 0, 0);
      phase = "R6";
      step(1, 4, 0, 2, 0, 0, 16'h40);
      step(1, 7, 0, 0, 0, 2, 0);
      step(1, 1, 0, 3, 0, 0, 0);
      step(1, 6, 0, 3, 0, 0, 0);
      step(1, 1, 0, 3, 0, 0, 16'h7777);        // discarded during busy
      step(1, 12, 0, 0, 3, 0, 0);
      step(1, 6, 4, 1, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      step(1, 12, 0, 0, 1, 0, 0);
      phase = "R7";
      step(1, 5, 0, 0, 0, 0, 16'd4);
      step(1, 8, 3, 0, 0, 0, 0);
      step(1, 1, 0, 1, 0, 0, 16'd111);
      step(1, 9, 0, 0, 0, 0, 0);
      step(1, 1, 0, 1, 0, 0, 16'd222);
      step(1, 5, 0, 0, 0, 0, 16'd6);
      step(1, 8, 4, 0, 0, 0, 0);
      step(1, 4, 0, 1, 1, 0, 16'd1);
      step(1, 9, 0, 0, 0, 0, 0);
      step(1, 4, 0, 1, 1, 0, 16'd2);
      step(1, 10, 0, 0, 0, 0, 0);
      step(1, 10, 0, 0, 0, 0, 0);
      step(1, 12, 0, 0, 1, 0, 0);
      phase = "R9";
      step(1, 5, 0, 0, 0, 0, 16'd0);
      step(1, 11, 4, 0, 0, 0, 0);
      step(1, 11, 3, 0, 0, 0, 0);
      step(1, 11, 1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0);
      step(1, 8, 7, 0, 0, 0, 0);
      step(1, 11, 1, 0, 0, 0, 0);
      chk("R9", "empty vote_all", LANES*DW'(vall), LANES*DW'(1'b1));
      step(1, 10, 0, 0, 0, 0, 0);
      phase = "R10";
      step(1, 1, 0, 2, 0, 0, 16'd9);
      step(1, 12, 0, 2, 1, 0, 0);
      step(1, 12, 0, 0, 2, 0, 0);
      phase = "R8";
      step(1, 10, 0, 0, 0, 0, 0);
      step(1, 9, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0);
      do_reset();
      phase = "R8";
      step(1, 5, 0, 0, 0, 0, 16'd0);
      step(1, 2, 0, 0, 0, 0, 0);
      step(1, 5, 0, 0, 0, 0, 16'd4);
      for (int k = 0; k < DEPTH + 1; k++) step(1, 8, 3 + (k % 2), 0, 0, 0, 0);
      for (int k = 0; k < DEPTH; k++) step(1, 10, 0, 0, 0, 0, 0);
      chk("R8", "mask restored", LANES*DW'(amask), LANES*DW'({LANES{1'b1}}));
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule